// File: doc/BRIEF.md
# Word-Length-Masked Special Character Detector

This block sits between a UART receive deserialiser and the receive FIFO. Each received character is handed on to the FIFO. When detection is switched on, the block also compares the character with a programmed special character. A character that matches is not removed from the stream. It is written to the FIFO like any other character, and it raises a sticky detect flag. That flag is the same status indication used for flow control, and it can drive an interrupt request.

The comparison only looks at the data bits in use. A two-bit word-length select picks 5, 6, 7 or 8 bits. Bits above the selected length are ignored on both operands, and they are forced to zero on the forwarded data. The forwarded write and the flag update both come from one register stage, so the flag changes on the same cycle the matching character reaches the FIFO. A software read of the interrupt status clears the flag.

Top module: `spcd_top`

## Requirements
- R1: After synchronous reset `fifo_wr`, `det_flag` and `irq` are all 0.
- R2: A cycle with `rx_valid`=1 produces `fifo_wr`=1 on the next cycle. On that cycle `fifo_data` holds the low N bits of `rx_data`, and every bit above them is 0. N is 5, 6, 7 or 8 for `wlen_sel` = 0, 1, 2 or 3.
- R3: If `det_en`=1 and the low N bits of `rx_data` equal the low N bits of `spec_char`, then `det_flag` is 1 on the same cycle that character's `fifo_wr` is 1. A match still produces the FIFO write.
- R4: Bits of `rx_data` and `spec_char` above bit N-1 have no effect on whether a match is found.
- R5: With `det_en`=0, a received character never sets `det_flag`, even when its bits match `spec_char`.
- R6: `det_flag` stays 1 until a cycle with `isr_read`=1. On the cycle after that read it is 0, unless a new match is being set in the same cycle.
- R7: If a match sets the flag in the same cycle that `isr_read` clears it, the set wins and `det_flag` stays 1.
- R8: `irq` is 1 exactly when `det_flag`=1 and `irq_en`=1.
- R9: A cycle with `rx_valid`=0 produces `fifo_wr`=0 on the next cycle and never sets `det_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| wlen_sel | input | 2 | Word length: 0=5, 1=6, 2=7, 3=8 bits |
| det_en | input | 1 | Special character detection enable |
| spec_char | input | 8 | Programmed special character |
| irq_en | input | 1 | Interrupt enable for the detect flag |
| isr_read | input | 1 | Status read strobe; clears the detect flag |
| fifo_wr | output | 1 | Write strobe towards the receive FIFO |
| fifo_data | output | 8 | Masked character towards the receive FIFO |
| det_flag | output | 1 | Sticky special-character detect status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the ones where characters differ only in bits above the word length, because those must still count as a match. Another is a match arriving on the very cycle software clears the flag. The stimulus sweeps every word length against all 256 received values and several special characters. Each special character is chosen with upper bits that differ from many received values, so masking is tested across the whole code space. A directed sequence then lines up a matching character with the status-read strobe in the same cycle.

// File: rtl/spcd_pkg.sv
package spcd_pkg;

    parameter int CHAR_W   = 8;
    parameter int MIN_BITS = 5;

    typedef enum logic [1:0] {
        WL_5 = 2'd0,
        WL_6 = 2'd1,
        WL_7 = 2'd2,
        WL_8 = 2'd3
    } wlen_e;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    typedef struct packed {
        logic              wr;
        logic [CHAR_W-1:0] data;
        logic              hit;
    } fwd_char_t;

    // Number of data bits selected by a word-length code.
    function automatic int wlen_bits(wlen_e wl);
        return MIN_BITS + int'(wl);
    endfunction

    // Mask with the low wlen_bits(wl) bits set.
    function automatic logic [CHAR_W-1:0] wlen_mask(wlen_e wl);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (i < wlen_bits(wl));
        end
        return m;
    endfunction

endpackage

// File: rtl/spcd_mask.sv
module spcd_mask
    import spcd_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  wlen_e          wl,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   mask,
    output logic [W-1:0]   dout
);
    logic [CHAR_W-1:0] full_mask;

    always_comb begin
        full_mask = wlen_mask(wl);
    end

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            if (b < CHAR_W) begin : g_live
                assign mask[b] = full_mask[b];
            end else begin : g_dead
                assign mask[b] = 1'b0;
            end
            assign dout[b] = din[b] & mask[b];
        end
    endgenerate

endmodule

// File: rtl/spcd_cmp.sv
module spcd_cmp #(
    parameter int W = spcd_pkg::CHAR_W
) (
    input  logic           en,
    input  logic           valid,
    input  logic [W-1:0]   mask,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           hit
);
    logic [W-1:0] diff;

    always_comb begin
        diff = (a ^ b) & mask;
        hit  = en && valid && (diff == '0);
    end

endmodule

// File: rtl/spcd_flag.sv
module spcd_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;      // set has priority over a simultaneous clear
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/spcd_top.sv
module spcd_top
    import spcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [1:0]        wlen_sel,
    input  logic              det_en,
    input  logic [CHAR_W-1:0] spec_char,
    input  logic              irq_en,
    input  logic              isr_read,
    output logic              fifo_wr,
    output logic [CHAR_W-1:0] fifo_data,
    output logic              det_flag,
    output logic              irq
);
    wlen_e             wl;
    rx_char_t          rx_in;
    fwd_char_t         nxt, cur;
    logic [CHAR_W-1:0] mask;
    logic [CHAR_W-1:0] data_m;
    logic              hit;

    assign wl    = wlen_e'(wlen_sel);
    assign rx_in = '{valid: rx_valid, data: rx_data};

    spcd_mask #(.W(CHAR_W)) u_mask (
        .wl   (wl),
        .din  (rx_in.data),
        .mask (mask),
        .dout (data_m)
    );

    spcd_cmp #(.W(CHAR_W)) u_cmp (
        .en    (det_en),
        .valid (rx_in.valid),
        .mask  (mask),
        .a     (rx_in.data),
        .b     (spec_char),
        .hit   (hit)
    );

    always_comb begin
        nxt.wr   = rx_in.valid;
        nxt.data = rx_in.valid ? data_m : '0;
        nxt.hit  = hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    // Flag lands on the same edge as the forwarded write.
    spcd_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (hit),
        .clr  (isr_read),
        .flag (det_flag)
    );

    assign fifo_wr   = cur.wr;
    assign fifo_data = cur.data;
    assign irq       = det_flag & irq_en;

endmodule

// File: rtl/spcd_chk.sv
module spcd_chk
    import spcd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_data,
    input logic [1:0]        wlen_sel,
    input logic              det_en,
    input logic [CHAR_W-1:0] spec_char,
    input logic              isr_read,
    input logic              fifo_wr,
    input logic [CHAR_W-1:0] fifo_data,
    input logic              det_flag,
    input logic              irq
);
    logic [CHAR_W-1:0] cmask;
    assign cmask = wlen_mask(wlen_e'(wlen_sel));

    AST_WR_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> fifo_wr); // R2
    AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !fifo_wr); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> ((fifo_data & ~$past(cmask)) == '0)); // R2
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && det_en && (((rx_data ^ spec_char) & cmask) == '0)) |=> (det_flag && fifo_wr)); // R3
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!det_en && !det_flag) |=> !det_flag); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (det_flag && !isr_read) |=> det_flag); // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (isr_read && !rx_valid) |=> !det_flag); // R6
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !det_flag) |=> !det_flag); // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> det_flag); // R8

endmodule

bind spcd_top spcd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .wlen_sel  (wlen_sel),
    .det_en    (det_en),
    .spec_char (spec_char),
    .isr_read  (isr_read),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .det_flag  (det_flag),
    .irq       (irq)
);

// File: tb/spcd_top_tb.sv
module spcd_top_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic [1:0] wlen_sel;
    logic       det_en;
    logic [7:0] spec_char;
    logic       irq_en;
    logic       isr_read;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic       det_flag;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spcd_top u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .wlen_sel(wlen_sel), .det_en(det_en), .spec_char(spec_char),
        .irq_en(irq_en), .isr_read(isr_read), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .det_flag(det_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] emask(input logic [1:0] wl);
        return 8'((16'd1 << (5 + int'(wl))) - 16'd1);
    endfunction

    task automatic clear_flag();
        rx_valid = 1'b0;
        isr_read = 1'b1;
        step();
        isr_read = 1'b0;
        check("R6 clear", {7'd0, det_flag}, 8'd0);
    endtask

    task automatic send(input logic [7:0] d, input logic [1:0] wl,
                        input logic [7:0] sc, input logic en);
        logic [7:0] m;
        logic       exp_hit;
        m        = emask(wl);
        exp_hit  = en && (((d ^ sc) & m) == 8'd0);
        rx_valid = 1'b1;
        rx_data  = d;
        wlen_sel = wl;
        spec_char = sc;
        det_en   = en;
        step();
        rx_valid = 1'b0;
        check("R2 wr", {7'd0, fifo_wr}, 8'd1);
        check("R2 data", fifo_data, d & m);
        if (en) check("R3/R4 flag", {7'd0, det_flag}, {7'd0, exp_hit});
        else    check("R5 flag", {7'd0, det_flag}, 8'd0);
        check("R8 irq", {7'd0, irq}, {7'd0, exp_hit & irq_en});
        if (det_flag) clear_flag();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] specs [4];
        specs[0] = 8'hE3; specs[1] = 8'h15; specs[2] = 8'h7F; specs[3] = 8'hA0;
        rst = 1'b1; rx_valid = 1'b0; rx_data = 8'hFF; wlen_sel = 2'd3;
        det_en = 1'b1; spec_char = 8'h00; irq_en = 1'b1; isr_read = 1'b0;
        @(negedge clk);
        step();
        step();
        check("R1 wr", {7'd0, fifo_wr}, 8'd0);
        check("R1 flag", {7'd0, det_flag}, 8'd0);
        check("R1 irq", {7'd0, irq}, 8'd0);
        rst = 1'b0;
        step();
        check("R9 idle wr", {7'd0, fifo_wr}, 8'd0);

        // R2 R3 R4: every word length, every character, several specials
        for (int wl = 0; wl < 4; wl++)
            for (int s = 0; s < 4; s++)
                for (int d = 0; d < 256; d++)
                    send(8'(d), 2'(wl), specs[s], 1'b1);

        // R5: disabled, exact matches must not flag
        for (int wl = 0; wl < 4; wl++)
            for (int d = 0; d < 256; d += 3)
                send(8'(d), 2'(wl), 8'(d), 1'b0);

        // R8: irq masked while flag set
        irq_en = 1'b0;
        send(8'h41, 2'd3, 8'h41, 1'b1);
        irq_en = 1'b1;

        // R6: sticky over idle cycles
        rx_valid = 1'b1; rx_data = 8'h5A; spec_char = 8'h5A; wlen_sel = 2'd3; det_en = 1'b1;
        step();
        rx_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            check("R6 sticky", {7'd0, det_flag}, 8'd1);
            check("R9 no wr", {7'd0, fifo_wr}, 8'd0);
        end

        // R7: set and clear in the same cycle
        rx_valid = 1'b1; isr_read = 1'b1; rx_data = 8'h5A;
        step();
        rx_valid = 1'b0; isr_read = 1'b0;
        check("R7 set wins", {7'd0, det_flag}, 8'd1);
        check("R7 wr", {7'd0, fifo_wr}, 8'd1);
        clear_flag();

        // R9: data on rx_data without valid does nothing
        rx_data = 8'h5A;
        step();
        check("R9 no wr", {7'd0, fifo_wr}, 8'd0);
        check("R9 no flag", {7'd0, det_flag}, 8'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule